// File: doc/BRIEF.md
# Multidrop 9-bit Serial Receiver with Address Filtering

This block receives asynchronous serial words on a shared multidrop line where every word holds eight data bits followed by a ninth mode bit. It oversamples the line, confirms each start bit at its centre and shifts in nine bits, least significant first. It then checks that the stop bit is high. Each complete word then passes through a delivery stage whose behaviour depends on the role the node plays on the bus.

As a peripheral, the node treats a word with the mode bit set as an address. It selects itself when the eight data bits equal its configured address, and it deselects itself on any other address. While selected it forwards data words (mode bit clear) and drops them otherwise. As a controller, the node forwards every word of a reply. The word carrying the mode bit closes the message. It is flagged as end of message and compared with an 8-bit running sum of the words that preceded it.

Top module: `mdb_rx_node`

## Requirements
- R1: A frame is a low start bit, nine bits sent least significant first, and a high stop bit. The first eight received bits form `out_data_o` (first bit at bit 0). The ninth bit appears as `out_mode_o`.
- R2: A low pulse on the idle line that ends before the middle of a bit time is not taken as a start bit and produces no output.
- R3: A stop bit sampled low gives a one-cycle `frame_err_o` pulse. The word is not delivered, and neither the selection state nor the running sum changes.
- R4: In peripheral mode (`ctrl_mode_i` = 0), a word with mode bit 1 whose data equals `node_addr_i` is delivered with `out_mode_o` = 1 and selects the node.
- R5: In peripheral mode, words with mode bit 0 are delivered while the node is selected and dropped while it is not. The node is unselected after reset.
- R6: In peripheral mode, a word with mode bit 1 and data different from `node_addr_i` is not delivered and deselects the node.
- R7: In controller mode (`ctrl_mode_i` = 1), every word is delivered. `out_eom_o` is 1 exactly when the delivered word has mode bit 1. In peripheral mode `out_eom_o` stays 0.
- R8: In controller mode, `sum_err_o` accompanies an end-of-message word. It is 1 when that word's data differs from the modulo-256 sum of the data of the words received since the previous end-of-message word or reset. The sum restarts at 0 after every end-of-message word.
- R9: `out_vld_o`, `frame_err_o` and `sum_err_o` are single-cycle pulses. After a synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| ctrl_mode_i | input | 1 | 1 = controller role, 0 = peripheral role |
| node_addr_i | input | 8 | Address of this node in peripheral mode |
| out_vld_o | output | 1 | One-cycle pulse: a word is delivered |
| out_data_o | output | 8 | Data bits of the delivered word |
| out_mode_o | output | 1 | Ninth bit of the delivered word |
| out_eom_o | output | 1 | Delivered word ends a controller-mode message |
| sum_err_o | output | 1 | End-of-message word does not match the running sum |
| frame_err_o | output | 1 | One-cycle pulse: stop bit was low |

## Verification
The bench sends bytes with only the lowest or only the highest bit set. A receiver that shifted bits in the wrong direction, or dropped or moved the ninth bit, would deliver a mirrored byte or a wrong mode. A framing error is injected while the node is selected, and again in the middle of a controller message. A design that let a broken frame change the selection or the sum would then drop the next data word or flag a false checksum error. Other cases cover sums that wrap past 255, a message made of only its final word, a sub-half-bit glitch, and a non-matching address followed by data that must disappear. Each of these catches a filter that fails to deselect, a checksum kept wider than eight bits, or a start detector with no mid-bit confirmation.

// File: rtl/mdb_rx_pkg.sv
package mdb_rx_pkg;
  localparam int WORD_DATA_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic                   mode;
    logic [WORD_DATA_W-1:0] data;
  } mdb_word_t;
endpackage

// File: rtl/mdb_rx_sync.sv
module mdb_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mdb_rx_tick.sv
module mdb_rx_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdb_rx_deser.sv
module mdb_rx_deser
  import mdb_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      rx_i,
  output logic      word_vld_o,
  output mdb_word_t word_o,
  output logic      frame_err_o
);
  localparam int NBITS = WORD_DATA_W + 1;
  localparam int HALF  = OVS / 2;
  localparam int CW    = $clog2(OVS);
  localparam int BW    = $clog2(NBITS + 1);

  rx_state_e        state;
  logic [CW-1:0]    ocnt;
  logic [BW-1:0]    bcnt;
  logic [NBITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RX_IDLE;
      ocnt        <= '0;
      bcnt        <= '0;
      shreg       <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      word_o      <= '0;
    end else begin
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (tick_i) begin
        case (state)
          RX_IDLE: begin
            if (!rx_i) begin
              state <= RX_START;
              ocnt  <= '0;
            end
          end
          RX_START: begin
            if (ocnt == CW'(HALF - 1)) begin
              ocnt <= '0;
              bcnt <= '0;
              state <= rx_i ? RX_IDLE : RX_BITS;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (ocnt == CW'(OVS - 1)) begin
              ocnt  <= '0;
              shreg <= {rx_i, shreg[NBITS-1:1]};
              if (bcnt == BW'(NBITS - 1)) state <= RX_STOP;
              else                        bcnt  <= bcnt + 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (ocnt == CW'(OVS - 1)) begin
              ocnt  <= '0;
              state <= RX_IDLE;
              if (rx_i) begin
                word_vld_o <= 1'b1;
                word_o     <= shreg;
              end else begin
                frame_err_o <= 1'b1;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R3
  frame_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_err_o && word_vld_o));
  // R9
  word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);
  // R9
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);
endmodule

// File: rtl/mdb_rx_filter.sv
module mdb_rx_filter
  import mdb_rx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctrl_mode_i,
  input  logic [WORD_DATA_W-1:0] node_addr_i,
  input  logic                   word_vld_i,
  input  mdb_word_t              word_i,
  input  logic                   frame_err_i,
  output logic                   out_vld_o,
  output mdb_word_t              out_word_o,
  output logic                   out_eom_o,
  output logic                   sum_err_o,
  output logic                   frame_err_o
);
  logic                   selected;
  logic [WORD_DATA_W-1:0] run_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      selected    <= 1'b0;
      run_sum     <= '0;
      out_vld_o   <= 1'b0;
      out_word_o  <= '0;
      out_eom_o   <= 1'b0;
      sum_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      out_vld_o   <= 1'b0;
      out_eom_o   <= 1'b0;
      sum_err_o   <= 1'b0;
      frame_err_o <= frame_err_i;
      if (word_vld_i) begin
        out_word_o <= word_i;
        if (ctrl_mode_i) begin
          out_vld_o <= 1'b1;
          if (word_i.mode) begin
            out_eom_o <= 1'b1;
            sum_err_o <= (word_i.data != run_sum);
            run_sum   <= '0;
          end else begin
            run_sum <= run_sum + word_i.data;
          end
        end else if (word_i.mode) begin
          if (word_i.data == node_addr_i) begin
            selected  <= 1'b1;
            out_vld_o <= 1'b1;
          end else begin
            selected <= 1'b0;
          end
        end else if (selected) begin
          out_vld_o <= 1'b1;
        end
      end
    end
  end

  // R3
  ferr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_i |=> !out_vld_o);
  // R5
  unsel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld_i && !ctrl_mode_i && !word_i.mode && !selected) |=> !out_vld_o);
  // R6
  addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld_i && !ctrl_mode_i && word_i.mode && (word_i.data != node_addr_i))
      |=> (!out_vld_o && !selected));
  // R7
  eom_mode_chk: assert property (@(posedge clk) disable iff (rst)
    out_eom_o |-> (out_vld_o && out_word_o.mode));
  // R8
  sum_err_eom_chk: assert property (@(posedge clk) disable iff (rst)
    sum_err_o |-> out_eom_o);
  // R9
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld_o |-> $past(word_vld_i));
endmodule

// File: rtl/mdb_rx_node.sv
module mdb_rx_node
  import mdb_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2,
  parameter int OVS           = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_i,
  input  logic                   ctrl_mode_i,
  input  logic [WORD_DATA_W-1:0] node_addr_i,
  output logic                   out_vld_o,
  output logic [WORD_DATA_W-1:0] out_data_o,
  output logic                   out_mode_o,
  output logic                   out_eom_o,
  output logic                   sum_err_o,
  output logic                   frame_err_o
);
  logic      rx_s;
  logic      tick;
  logic      w_vld;
  logic      w_ferr;
  mdb_word_t w_word;
  mdb_word_t o_word;

  mdb_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s)
  );

  mdb_rx_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  mdb_rx_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx_s),
    .word_vld_o(w_vld), .word_o(w_word), .frame_err_o(w_ferr)
  );

  mdb_rx_filter u_filter (
    .clk(clk), .rst(rst), .ctrl_mode_i(ctrl_mode_i), .node_addr_i(node_addr_i),
    .word_vld_i(w_vld), .word_i(w_word), .frame_err_i(w_ferr),
    .out_vld_o(out_vld_o), .out_word_o(o_word), .out_eom_o(out_eom_o),
    .sum_err_o(sum_err_o), .frame_err_o(frame_err_o)
  );

  assign out_data_o = o_word.data;
  assign out_mode_o = o_word.mode;

  // R7
  no_eom_periph_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_mode_i && !$past(ctrl_mode_i)) |-> !out_eom_o);
endmodule

// File: tb/sim_mdb_rx_node.sv
module sim_mdb_rx_node;
  localparam int DIV  = 2;
  localparam int OVS  = 16;
  localparam int BITC = DIV * OVS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic       ctrl = 1'b0;
  logic [7:0] addr = 8'h5A;
  logic       vld, mode, eom, serr, ferr;
  logic [7:0] data;

  typedef struct {
    bit         is_ferr;
    logic [7:0] d;
    bit         m;
    bit         e;
    bit         s;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   errors  = 0;
  logic [7:0] bsum = 8'h00;

  always #10 clk = ~clk;

  mdb_rx_node #(.CLKS_PER_TICK(DIV), .OVS(OVS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_i(rx), .ctrl_mode_i(ctrl), .node_addr_i(addr),
    .out_vld_o(vld), .out_data_o(data), .out_mode_o(mode), .out_eom_o(eom),
    .sum_err_o(serr), .frame_err_o(ferr)
  );

  task automatic drive(input logic b, input int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] d, input logic m, input bit good_stop);
    drive(1'b0, BITC);
    for (int i = 0; i < 8; i++) drive(d[i], BITC);
    drive(m, BITC);
    if (good_stop) drive(1'b1, BITC);
    else begin
      drive(1'b0, BITC * 3 / 4);
      drive(1'b1, BITC / 4);
    end
    drive(1'b1, 2 * BITC);
  endtask

  task automatic push(input bit f, input logic [7:0] d, input bit m, input bit e,
                      input bit s, input string r);
    exp_t x;
    x.is_ferr = f; x.d = d; x.m = m; x.e = e; x.s = s; x.req = r;
    exp_q.push_back(x);
  endtask

  // peripheral-mode word: model of R4/R5/R6 kept by caller via 'deliver'
  task automatic send_p(input logic [7:0] d, input logic m, input bit deliver,
                        input string r);
    if (deliver) push(0, d, m, 0, 0, r);
    send_raw(d, m, 1);
  endtask

  // controller-mode word with bench-side running sum (R7, R8)
  task automatic send_c(input logic [7:0] d, input logic m, input string r);
    if (m) begin
      push(0, d, 1, 1, (d != bsum), r);
      bsum = 8'h00;
    end else begin
      push(0, d, 0, 0, 0, r);
      bsum = bsum + d;
    end
    send_raw(d, m, 1);
  endtask

  task automatic send_bad(input logic [7:0] d, input logic m, input string r);
    push(1, 8'h00, 0, 0, 0, r);
    send_raw(d, m, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (vld || ferr)) begin
      exp_t x;
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: vld=%0b ferr=%0b data=%02h mode=%0b, expected nothing",
                 vld, ferr, data, mode);
      end else begin
        x = exp_q.pop_front();
        if (x.is_ferr) begin
          if (!ferr || vld) begin
            errors++;
            $display("FAIL %s: vld=%0b ferr=%0b, expected ferr=1 vld=0", x.req, vld, ferr);
          end
        end else if (!vld || ferr || data !== x.d || mode !== x.m ||
                     eom !== x.e || serr !== x.s) begin
          errors++;
          $display("FAIL %s: vld=%0b ferr=%0b d=%02h m=%0b eom=%0b serr=%0b, expected d=%02h m=%0b eom=%0b serr=%0b",
                   x.req, vld, ferr, data, mode, eom, serr, x.d, x.m, x.e, x.s);
        end
      end
    end
  end

  // pulse width check (R9)
  logic prev_vld = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_vld && vld) begin
      errors++;
      $display("FAIL R9: out_vld_o high two cycles, actual 1 expected 0");
    end
    prev_vld <= vld;
  end

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (vld || ferr || eom || serr) begin
      errors++;
      $display("FAIL R9 reset: vld=%0b ferr=%0b eom=%0b serr=%0b, expected all 0",
               vld, ferr, eom, serr);
    end
    drive(1'b1, 2 * BITC);

    // peripheral mode
    send_p(8'h11, 0, 0, "R5 unselected data");
    send_p(8'h33, 1, 0, "R6 foreign address");
    send_p(8'h5A, 1, 1, "R4 own address");
    send_p(8'h01, 0, 1, "R1 lsb pattern");
    send_p(8'h80, 0, 1, "R1 msb pattern");
    send_p(8'hFE, 0, 1, "R5 selected data");
    send_bad(8'h33, 1, "R3 framing error");
    send_p(8'h42, 0, 1, "R3 selection kept");
    // R2 glitch shorter than half a bit
    drive(1'b0, BITC / 4);
    drive(1'b1, 2 * BITC);
    send_p(8'h43, 0, 1, "R2 after glitch");
    send_p(8'h5B, 1, 0, "R6 near address");
    send_p(8'h44, 0, 0, "R6 deselected data");
    send_p(8'h5A, 1, 1, "R4 reselect");
    send_p(8'hA5, 0, 1, "R5 data after reselect");

    // controller mode
    ctrl = 1'b1;
    drive(1'b1, BITC);
    send_c(8'h10, 0, "R7 reply word");
    send_c(8'h20, 0, "R7 reply word");
    send_c(8'h30, 0, "R7 reply word");
    send_c(8'h60, 1, "R8 good sum");
    send_c(8'hF0, 0, "R7 reply word");
    send_c(8'h20, 0, "R7 reply word");
    send_c(8'h11, 1, "R8 bad sum wrap");
    send_c(8'hFF, 0, "R7 reply word");
    send_c(8'h01, 0, "R7 reply word");
    send_c(8'h00, 1, "R8 good sum wrap");
    send_c(8'h05, 0, "R7 reply word");
    send_bad(8'h77, 0, "R3 framing error ctrl");
    send_c(8'h05, 1, "R3 sum unchanged");
    send_c(8'h00, 1, "R8 lone final ok");
    send_c(8'h01, 1, "R8 lone final bad");

    drive(1'b1, 4 * BITC);
    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing outputs: actual %0d pending, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule